// File: doc/BRIEF.md
# Hit Time Stamp Encoder

This block turns one sampled hit into a binary time stamp. When a hit arrives, the block receives three captured values: a 32-tap snapshot of a delay-locked line, and two copies of a coarse counter that runs synchronously to the clock. One counter copy advances on the rising clock edge and the other on the falling edge. The block encodes where the clock edge sits in the tap snapshot and uses that as the fine time. It then uses the same position to choose whichever counter copy was sampled far from its own transition. The result is a coarse count that is never off by one, whatever the phase of the hit.

A programmable shift coarsens the bin size by clearing low fine bits. A mode setting chooses which edges are reported: leading only, trailing only, both, or pairs. In pair mode, a leading edge is held per channel. The matching trailing edge then emits one word that holds the leading time and the pulse width, with the width saturated.

Each result is registered once and marked by a one-cycle valid strobe.

Top module: `hit_time_encoder`

## Requirements
- R1: A tap snapshot equal to 2^k-1 (bits 0..k-1 set, k from 0 to 31) gives a fine time of k, placed in word bits 4:0 at full resolution.
- R2: Any other snapshot, including all 32 taps set, raises out_bubble and forces the fine field to 0. The coarse field then comes from the rising-edge copy.
- R3: When the fine index is below 16, the coarse field is the falling-edge copy plus one, modulo 4096. Otherwise it is the rising-edge copy.
- R4: res_sel 0 keeps all five fine bits. res_sel 1 clears fine bit 0. res_sel 2 and 3 clear fine bits 2:0.
- R5: out_valid pulses in the cycle after the hit cycle. In non-pair modes the word is {edge (bit 20), channel (19:17), coarse (16:5), fine (4:0)}, where edge is 0 for leading and 1 for trailing.
- R6: edge_mode 0 reports only leading edges and edge_mode 1 reports only trailing edges. An edge of the other kind produces no output.
- R7: edge_mode 2 reports every hit, each carrying its own edge flag.
- R8: In edge_mode 3, a leading edge produces no output and is stored for its channel. A following trailing edge on that channel emits {1, channel, stored time stamp bits 16:8, width[7:0]}. Its out_bubble is the OR of the two hits' bubble flags.
- R9: The width is (trailing time stamp − leading time stamp) modulo 2^17, saturated to 255. A time stamp is {coarse, masked fine}.
- R10: In edge_mode 3, a trailing edge on a channel with no stored leading edge produces nothing. A second leading edge replaces the stored one, and a completed pair clears the store.
- R11: Reset drops out_valid and clears every stored leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A captured hit is present this cycle |
| hit_edge | input | 1 | 0 leading edge, 1 trailing edge |
| hit_chan | input | 3 | Channel number |
| hit_taps | input | 32 | Tap snapshot of the delay line |
| cnt_rise | input | 12 | Counter copy advancing on the rising clock edge |
| cnt_fall | input | 12 | Counter copy advancing on the falling clock edge |
| res_sel | input | 2 | Resolution setting |
| edge_mode | input | 2 | 0 leading, 1 trailing, 2 both, 3 pair |
| out_valid | output | 1 | One-cycle result strobe |
| out_word | output | 21 | Encoded result |
| out_bubble | output | 1 | Snapshot was not a clean thermometer |

## Verification
The counter copies are driven with values that disagree, for example a rising copy that is plainly wrong when the tap index is low. A design that picked the wrong copy, or that forgot the +1 correction, would then report a coarse count off by one or more. Tap index 0 combined with a falling copy of 4095 checks the wrap to 0, and indices 15 and 16 bracket the point where the selection switches. Snapshots with a hole in them and the all-ones snapshot must raise the bubble flag instead of being treated as a count of set bits. In pair mode, the bench covers widths that saturate, widths that wrap across the time stamp range, orphan trailing edges, overwritten leading edges, and a reset between the two halves of a pair; any of these would otherwise leak a word or report a stale leading time.

// File: rtl/hte_pkg.sv
package hte_pkg;
  typedef enum logic [1:0] {
    MODE_LEAD  = 2'd0,
    MODE_TRAIL = 2'd1,
    MODE_BOTH  = 2'd2,
    MODE_PAIR  = 2'd3
  } edge_mode_e;

  function automatic int drop_bits(input logic [1:0] sel, input int d1, input int d2);
    case (sel)
      2'd0:    drop_bits = 0;
      2'd1:    drop_bits = d1;
      default: drop_bits = d2;
    endcase
  endfunction
endpackage

// File: rtl/tap_encoder.sv
module tap_encoder #(
  parameter int TAPS   = 32,
  parameter int FINE_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]   taps,
  output logic [FINE_W-1:0] fine,
  output logic              bubble
);
  localparam int CNT_W = $clog2(TAPS + 1);

  logic [CNT_W-1:0] ones;
  logic             therm;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + CNT_W'(taps[i]);
    end
  end

  // thermometer with its low end anchored: adding one clears every set bit
  assign therm  = ((taps & (taps + TAPS'(1))) == '0) && (taps != {TAPS{1'b1}});
  assign bubble = ~therm;
  assign fine   = therm ? ones[FINE_W-1:0] : '0;
endmodule

// File: rtl/coarse_resolver.sv
module coarse_resolver #(
  parameter int FINE_W   = 5,
  parameter int COARSE_W = 12
) (
  input  logic [FINE_W-1:0]   fine,
  input  logic                bubble,
  input  logic [COARSE_W-1:0] cnt_rise,
  input  logic [COARSE_W-1:0] cnt_fall,
  output logic [COARSE_W-1:0] coarse
);
  logic early_half;

  // edge index in the lower half: the rising copy may be mid-transition
  assign early_half = ~bubble & ~fine[FINE_W-1];
  assign coarse     = early_half ? cnt_fall + COARSE_W'(1) : cnt_rise;
endmodule

// File: rtl/lead_store.sv
module lead_store #(
  parameter int CHANNELS = 8,
  parameter int CH_W     = $clog2(CHANNELS),
  parameter int TS_W     = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            clr_en,
  input  logic [CH_W-1:0] chan,
  input  logic [TS_W-1:0] wr_ts,
  input  logic            wr_bub,
  output logic            rd_seen,
  output logic [TS_W-1:0] rd_ts,
  output logic            rd_bub
);
  logic [TS_W-1:0]     ts_q  [CHANNELS];
  logic [CHANNELS-1:0] seen_q;
  logic [CHANNELS-1:0] bub_q;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        seen_q[c] <= 1'b0;
        bub_q[c]  <= 1'b0;
        ts_q[c]   <= '0;
      end else if (chan == CH_W'(c)) begin
        if (wr_en) begin
          seen_q[c] <= 1'b1;
          bub_q[c]  <= wr_bub;
          ts_q[c]   <= wr_ts;
        end else if (clr_en) begin
          seen_q[c] <= 1'b0;
        end
      end
    end
  end

  assign rd_seen = seen_q[chan];
  assign rd_ts   = ts_q[chan];
  assign rd_bub  = bub_q[chan];
endmodule

// File: rtl/hit_time_encoder.sv
module hit_time_encoder #(
  parameter int TAPS     = 32,
  parameter int COARSE_W = 12,
  parameter int CHANNELS = 8,
  parameter int WID_W    = 8,
  parameter int DROP_MID = 1,
  parameter int DROP_LOW = 3
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         hit_valid,
  input  logic                                         hit_edge,
  input  logic [$clog2(CHANNELS)-1:0]                  hit_chan,
  input  logic [TAPS-1:0]                              hit_taps,
  input  logic [COARSE_W-1:0]                          cnt_rise,
  input  logic [COARSE_W-1:0]                          cnt_fall,
  input  logic [1:0]                                   res_sel,
  input  logic [1:0]                                   edge_mode,
  output logic                                         out_valid,
  output logic [COARSE_W+$clog2(TAPS)+$clog2(CHANNELS):0] out_word,
  output logic                                         out_bubble
);
  import hte_pkg::*;

  localparam int FINE_W = $clog2(TAPS);
  localparam int CH_W   = $clog2(CHANNELS);
  localparam int TS_W   = COARSE_W + FINE_W;
  localparam int WORD_W = 1 + CH_W + TS_W;
  localparam logic [TS_W-1:0] WID_MAX = TS_W'((1 << WID_W) - 1);

  logic [FINE_W-1:0]   fine_raw, fine_mask, fine;
  logic                bubble;
  logic [COARSE_W-1:0] coarse;
  logic [TS_W-1:0]     ts, lead_ts, diff;
  logic [WID_W-1:0]    width;
  logic                lead_seen, lead_bub;
  logic                store_lead, clear_lead, emit;
  logic [WORD_W-1:0]   word_d;
  logic                bub_d;
  edge_mode_e          mode;

  tap_encoder #(.TAPS(TAPS), .FINE_W(FINE_W)) u_taps (
    .taps(hit_taps), .fine(fine_raw), .bubble(bubble)
  );

  coarse_resolver #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_coarse (
    .fine(fine_raw), .bubble(bubble), .cnt_rise(cnt_rise),
    .cnt_fall(cnt_fall), .coarse(coarse)
  );

  assign fine_mask = FINE_W'({FINE_W{1'b1}} << drop_bits(res_sel, DROP_MID, DROP_LOW));
  assign fine      = fine_raw & fine_mask;
  assign ts        = {coarse, fine};
  assign mode      = edge_mode_e'(edge_mode);

  always_comb begin
    store_lead = 1'b0;
    clear_lead = 1'b0;
    emit       = 1'b0;
    case (mode)
      MODE_LEAD:  emit = hit_valid & ~hit_edge;
      MODE_TRAIL: emit = hit_valid & hit_edge;
      MODE_BOTH:  emit = hit_valid;
      default: begin
        store_lead = hit_valid & ~hit_edge;
        emit       = hit_valid & hit_edge & lead_seen;
        clear_lead = emit;
      end
    endcase
  end

  lead_store #(.CHANNELS(CHANNELS), .CH_W(CH_W), .TS_W(TS_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(store_lead), .clr_en(clear_lead),
    .chan(hit_chan), .wr_ts(ts), .wr_bub(bubble),
    .rd_seen(lead_seen), .rd_ts(lead_ts), .rd_bub(lead_bub)
  );

  assign diff  = ts - lead_ts;
  assign width = (diff > WID_MAX) ? WID_MAX[WID_W-1:0] : diff[WID_W-1:0];

  always_comb begin
    if (mode == MODE_PAIR) begin
      word_d = {1'b1, hit_chan, lead_ts[TS_W-1:WID_W], width};
      bub_d  = bubble | lead_bub;
    end else begin
      word_d = {hit_edge, hit_chan, ts};
      bub_d  = bubble;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_bubble <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_word   <= word_d;
        out_bubble <= bub_d;
      end
    end
  end

  // R5
  valid_follows_hit_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(hit_valid));

  // R5
  chan_carried_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[WORD_W-2 -: CH_W] == $past(hit_chan));

  // R8
  pair_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(edge_mode) == 2'd3) |-> out_word[WORD_W-1]);

  // R6
  lead_only_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(edge_mode) == 2'd0) |-> !out_word[WORD_W-1]);

  // R2
  bubble_zero_fine_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bubble && $past(edge_mode) != 2'd3) |-> out_word[FINE_W-1:0] == '0);

  // R4
  coarse_res_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(edge_mode) != 2'd3 && $past(res_sel) >= 2'd2)
      |-> out_word[DROP_LOW-1:0] == '0);
endmodule

// File: tb/hit_time_encoder_test.sv
module hit_time_encoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hit_valid = 1'b0;
  logic        hit_edge = 1'b0;
  logic [2:0]  hit_chan = '0;
  logic [31:0] hit_taps = '0;
  logic [11:0] cnt_rise = '0;
  logic [11:0] cnt_fall = '0;
  logic [1:0]  res_sel = '0;
  logic [1:0]  edge_mode = 2'd2;
  logic        out_valid;
  logic [20:0] out_word;
  logic        out_bubble;

  int checks = 0;
  int fails  = 0;
  logic [21:0] exp_q[$];
  string       tag_q[$];
  logic        mdl_seen[8];
  logic [16:0] mdl_ts[8];
  logic        mdl_bub[8];

  hit_time_encoder uut (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_edge(hit_edge),
    .hit_chan(hit_chan), .hit_taps(hit_taps), .cnt_rise(cnt_rise),
    .cnt_fall(cnt_fall), .res_sel(res_sel), .edge_mode(edge_mode),
    .out_valid(out_valid), .out_word(out_word), .out_bubble(out_bubble)
  );

  always #10 clk = ~clk;

  // reference: {bubble, time stamp}
  function automatic logic [17:0] model_ts(logic [31:0] t, logic [11:0] r,
                                           logic [11:0] f, logic [1:0] rs);
    int k = -1;
    logic [4:0] fn;
    logic [11:0] co;
    for (int i = 0; i < 32; i++) if (t == (32'h1 << i) - 32'h1) k = i;
    if (k < 0) return {1'b1, r, 5'd0};
    fn = 5'(k);
    co = (k < 16) ? f + 12'd1 : r;
    if (rs == 2'd1) fn[0] = 1'b0;
    else if (rs >= 2'd2) fn[2:0] = 3'b0;
    return {1'b0, co, fn};
  endfunction

  task automatic hit(input logic e, input logic [2:0] ch, input logic [31:0] t,
                     input logic [11:0] r, input logic [11:0] f, input string tag);
    logic [17:0] m;
    logic [16:0] d;
    logic [7:0]  w;
    @(negedge clk);
    hit_valid = 1'b1; hit_edge = e; hit_chan = ch; hit_taps = t;
    cnt_rise = r; cnt_fall = f;
    m = model_ts(t, r, f, res_sel);
    case (edge_mode)
      2'd0: if (!e) begin exp_q.push_back({m[17], e, ch, m[16:0]}); tag_q.push_back(tag); end
      2'd1: if (e)  begin exp_q.push_back({m[17], e, ch, m[16:0]}); tag_q.push_back(tag); end
      2'd2: begin exp_q.push_back({m[17], e, ch, m[16:0]}); tag_q.push_back(tag); end
      default: begin
        if (!e) begin
          mdl_seen[ch] = 1'b1; mdl_ts[ch] = m[16:0]; mdl_bub[ch] = m[17];
        end else if (mdl_seen[ch]) begin
          d = m[16:0] - mdl_ts[ch];
          w = (d > 17'd255) ? 8'd255 : d[7:0];
          exp_q.push_back({m[17] | mdl_bub[ch], 1'b1, ch, mdl_ts[ch][16:8], w});
          tag_q.push_back(tag);
          mdl_seen[ch] = 1'b0;
        end
      end
    endcase
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic quiet(input string tag);
    @(posedge clk); #1;
    checks++;
    if (out_valid) begin
      fails++;
      $display("FAIL %s: out_valid=%0b expected 0", tag, out_valid);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < 8; i++) mdl_seen[i] = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL unexpected output: word=%h bubble=%0b expected none", out_word, out_bubble);
        end else begin
          logic [21:0] ex;
          string tg;
          ex = exp_q.pop_front();
          tg = tag_q.pop_front();
          if ({out_bubble, out_word} !== ex) begin
            fails++;
            $display("FAIL %s: bubble/word=%0b/%h expected %0b/%h", tg, out_bubble, out_word, ex[21], ex[20:0]);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl_seen[i] = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R11 reset: out_valid=%0b expected 0", out_valid);
    end
    rst = 1'b0;

    // R1 R3 R5: fine index and copy selection, both edges reported (R7)
    edge_mode = 2'd2; res_sel = 2'd0;
    hit(1'b0, 3'd1, 32'h0000_001F, 12'd777, 12'd99,  "R1 R3 R5 k=5");
    hit(1'b0, 3'd2, 32'h000F_FFFF, 12'd200, 12'd555, "R1 R3 k=20");
    hit(1'b1, 3'd4, 32'h0000_7FFF, 12'd5,   12'd299, "R3 R7 k=15");
    hit(1'b0, 3'd6, 32'h0000_FFFF, 12'd400, 12'd123, "R3 k=16");
    hit(1'b0, 3'd0, 32'h0000_0000, 12'd9,   12'd4095,"R3 wrap k=0");
    hit(1'b1, 3'd7, 32'h7FFF_FFFF, 12'd4095,12'd0,   "R1 R7 k=31");
    // R2 bubbles
    hit(1'b0, 3'd3, 32'h0000_00F5, 12'd321, 12'd17,  "R2 hole");
    hit(1'b0, 3'd3, 32'hFFFF_FFFF, 12'd88,  12'd17,  "R2 all ones");
    hit(1'b0, 3'd3, 32'h8000_0000, 12'd60,  12'd17,  "R2 top only");
    // R4 resolution
    res_sel = 2'd1; hit(1'b0, 3'd1, 32'h0000_007F, 12'd50, 12'd49, "R4 res1 k=7");
    res_sel = 2'd2; hit(1'b0, 3'd1, 32'h0000_7FFF, 12'd50, 12'd49, "R4 res2 k=15");
    res_sel = 2'd3; hit(1'b0, 3'd1, 32'h7FFF_FFFF, 12'd50, 12'd49, "R4 res3 k=31");
    res_sel = 2'd0;
    // R6 edge filtering
    edge_mode = 2'd0;
    hit(1'b1, 3'd2, 32'h0000_0003, 12'd10, 12'd10, "R6 trail dropped");
    quiet("R6 trailing ignored in lead mode");
    hit(1'b0, 3'd2, 32'h0000_0003, 12'd10, 12'd10, "R6 lead kept");
    edge_mode = 2'd1;
    hit(1'b0, 3'd2, 32'h0000_0003, 12'd10, 12'd10, "R6 lead dropped");
    quiet("R6 leading ignored in trail mode");
    hit(1'b1, 3'd2, 32'h0003_FFFF, 12'd11, 12'd10, "R6 trail kept");
    // R8 R9 R10 pair mode
    edge_mode = 2'd3;
    hit(1'b0, 3'd3, 32'h0000_00FF, 12'd100, 12'd99, "R8 lead stored");
    quiet("R8 leading gives no output");
    hit(1'b1, 3'd3, 32'h00FF_FFFF, 12'd102, 12'd1,  "R8 R9 width");
    hit(1'b0, 3'd4, 32'h0000_0001, 12'd10,  12'd9,  "R9 lead");
    hit(1'b1, 3'd4, 32'h0000_0001, 12'd900, 12'd899,"R9 saturate");
    hit(1'b0, 3'd5, 32'h0FFF_FFFF, 12'd4095,12'd0,  "R9 lead near top");
    hit(1'b1, 3'd5, 32'h0000_0007, 12'd1,   12'd0,  "R9 wrap");
    hit(1'b1, 3'd6, 32'h0000_0007, 12'd1,   12'd0,  "R10 orphan");
    quiet("R10 orphan trailing ignored");
    hit(1'b1, 3'd5, 32'h0000_0007, 12'd3,   12'd2,  "R10 cleared after pair");
    quiet("R10 store cleared by pair");
    hit(1'b0, 3'd7, 32'h0000_000F, 12'd20,  12'd19, "R10 first lead");
    hit(1'b0, 3'd7, 32'h0000_F0F0, 12'd40,  12'd39, "R10 second lead bubble");
    hit(1'b1, 3'd7, 32'h0000_03FF, 12'd45,  12'd44, "R10 R8 overwrite");
    // R11 reset clears stored leading edge
    hit(1'b0, 3'd2, 32'h0000_0003, 12'd70, 12'd69, "R11 lead before reset");
    do_reset();
    hit(1'b1, 3'd2, 32'h0000_0003, 12'd72, 12'd71, "R11 trail after reset");
    quiet("R11 store cleared by reset");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 missing outputs: %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule